// File: doc/BRIEF.md
# Signed-Scalar Bigint Multiply Sequencer

This block multiplies an unsigned multi-limb big integer by one signed 64-bit scalar. A start command carries the scalar and the number of limbs. The limbs then arrive over a valid/ready input, least significant limb first. For each limb the block performs one mixed-sign multiply-add: the limb is taken as unsigned, the scalar as two's complement, and the running carry word is sign-extended and added. The low half of each 128-bit sum leaves on a valid/ready output as the result limb for that position. The high half replaces the carry and becomes the addend for the next limb.

After the last limb has been accepted, the block emits the remaining carry as the most significant result word and flags it as last. The sum of all emitted words, each weighted by its limb position, equals the signed product. A count of zero is refused with a one-cycle error pulse. A start command that arrives while a sequence is in progress is dropped. Back-pressure on the output stalls the walk without losing any state.

Top module: `bigint_smul_seq`

## Requirements
- R1: After reset, out_valid, in_ready, busy and start_err are all 0.
- R2: Each step treats in_limb as unsigned and the scalar as two's complement, and computes limb*scalar + carry modulo 2^128, with the carry sign-extended from 64 to 128 bits. Bits 63:0 of that sum are emitted on out_data as the result limb.
- R3: Bits 127:64 of each step's sum become the carry for the next limb. The carry is zero when a sequence starts.
- R4: One multiply-add is done per accepted input limb (in_valid and in_ready both 1). Result limbs leave in the same ascending order with out_last 0, and out_valid is 1 in the cycle after each accepted limb.
- R5: After the count-th limb, exactly one extra word is emitted with out_last 1. That word holds the final carry.
- R6: start_count is 8 bits wide (1 to 255 limbs). A start in idle with count 0 raises start_err for exactly the following cycle, leaves busy at 0 and emits nothing.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values, out_valid stays 1 and in_ready is 0.
- R8: A start command (start_valid 1) while busy is 1 is ignored. It changes neither the results, the carry nor start_err.
- R9: busy is 1 from the cycle after an accepted start until the final carry word is loaded into the output register. busy is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command strobe |
| start_scalar | input | 64 | Signed scalar multiplier |
| start_count | input | 8 | Number of limbs, 1 to 255 |
| start_err | output | 1 | One-cycle pulse when a zero count is refused |
| busy | output | 1 | A sequence is in progress |
| in_valid | input | 1 | Input limb valid |
| in_limb | input | 64 | Unsigned input limb |
| in_ready | output | 1 | Block accepts an input limb |
| out_valid | output | 1 | Output word valid |
| out_data | output | 64 | Result limb or final carry |
| out_last | output | 1 | Marks the final carry word |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The bench goes after the sign corners: scalar zero, minus one, the most negative value and the most positive value, with all-ones and zero limbs. A design that sign-extended the limb, or zero-extended the carry, would produce wrong high words under these operands. Single-limb and 255-limb runs probe the counter ends: an off-by-one would drop the carry word or emit one word too many. Random output stalls and mid-run start commands expose a design that advances while stalled, or that restarts and clears its carry.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int LIMB_W = 64;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [LIMB_W-1:0] hi;
        logic [LIMB_W-1:0] lo;
    } wide_sum_t;

    typedef struct packed {
        logic              last;
        logic [LIMB_W-1:0] data;
    } out_word_t;

    // unsigned limb times signed scalar plus sign-extended carry, modulo 2^(2*LIMB_W)
    function automatic wide_sum_t mixed_mac(input logic [LIMB_W-1:0] limb,
                                            input logic [LIMB_W-1:0] scalar,
                                            input logic [LIMB_W-1:0] carry);
        logic [2*LIMB_W-1:0] a_ext, b_ext, c_ext, s;
        a_ext = {{LIMB_W{1'b0}}, limb};
        b_ext = {{LIMB_W{scalar[LIMB_W-1]}}, scalar};
        c_ext = {{LIMB_W{carry[LIMB_W-1]}}, carry};
        s     = a_ext * b_ext + c_ext;
        return wide_sum_t'(s);
    endfunction
endpackage

// File: rtl/bsm_mac.sv
module bsm_mac
    import bsm_pkg::*;
#(
    parameter int W = LIMB_W
) (
    input  logic [W-1:0] limb,
    input  logic [W-1:0] scalar,
    input  logic [W-1:0] carry,
    output logic [W-1:0] sum_lo,
    output logic [W-1:0] sum_hi
);
    wide_sum_t s;
    always_comb begin
        s      = mixed_mac(limb, scalar, carry);
        sum_lo = s.lo;
        sum_hi = s.hi;
    end
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
    import bsm_pkg::*;
#(
    parameter int W  = LIMB_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_valid,
    input  logic [W-1:0]  start_scalar,
    input  logic [CW-1:0] start_count,
    input  logic          in_valid,
    input  logic [W-1:0]  in_limb,
    input  logic          can_load,
    output logic          in_ready,
    output logic          busy,
    output logic          start_err,
    output logic          load,
    output out_word_t     load_word
);
    seq_state_t    state_q;
    logic [W-1:0]  scalar_q;
    logic [W-1:0]  carry_q;
    logic [CW-1:0] left_q;
    logic          err_q;
    logic [W-1:0]  step_lo, step_hi;
    logic          in_hs, flush_go;

    bsm_mac #(.W(W)) u_mac (
        .limb   (in_limb),
        .scalar (scalar_q),
        .carry  (carry_q),
        .sum_lo (step_lo),
        .sum_hi (step_hi)
    );

    always_comb begin
        in_ready       = (state_q == ST_RUN) && can_load;
        in_hs          = in_valid && in_ready;
        flush_go       = (state_q == ST_FLUSH) && can_load;
        load           = in_hs || flush_go;
        load_word.last = flush_go;
        load_word.data = in_hs ? step_lo : carry_q;
        busy           = (state_q != ST_IDLE);
        start_err      = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            scalar_q <= '0;
            carry_q  <= '0;
            left_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_valid) begin
                        if (start_count == '0) begin
                            err_q <= 1'b1;
                        end else begin
                            scalar_q <= start_scalar;
                            left_q   <= start_count;
                            carry_q  <= '0;
                            state_q  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (in_hs) begin
                        carry_q <= step_hi;
                        left_q  <= left_q - 1'b1;
                        if (left_q == CW'(1)) state_q <= ST_FLUSH;
                    end
                end
                ST_FLUSH: begin
                    if (can_load) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    carry_zero_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> carry_q == '0);
    // R8
    busy_start_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_valid) |=> !start_err);
    // R8
    busy_start_keeps_scalar_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(scalar_q));
endmodule

// File: rtl/bsm_outbuf.sv
module bsm_outbuf
    import bsm_pkg::*;
#(
    parameter int W = LIMB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  out_word_t    load_word,
    input  logic         out_ready,
    output logic         can_load,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    out_word_t word_q;
    logic      valid_q;

    always_comb begin
        can_load  = !valid_q || out_ready;
        out_valid = valid_q;
        out_data  = word_q.data;
        out_last  = word_q.last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            word_q  <= load_word;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/bigint_smul_seq.sv
module bigint_smul_seq
    import bsm_pkg::*;
#(
    parameter int W  = LIMB_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_valid,
    input  logic [W-1:0]  start_scalar,
    input  logic [CW-1:0] start_count,
    output logic          start_err,
    output logic          busy,
    input  logic          in_valid,
    input  logic [W-1:0]  in_limb,
    output logic          in_ready,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_last,
    input  logic          out_ready
);
    logic      can_load;
    logic      load;
    out_word_t load_word;

    bsm_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_valid  (start_valid),
        .start_scalar (start_scalar),
        .start_count  (start_count),
        .in_valid     (in_valid),
        .in_limb      (in_limb),
        .can_load     (can_load),
        .in_ready     (in_ready),
        .busy         (busy),
        .start_err    (start_err),
        .load         (load),
        .load_word    (load_word)
    );

    bsm_outbuf #(.W(W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // R7
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    // R4
    step_emits_limb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_last));
    // R6
    err_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_err |-> (!busy && !in_ready));
endmodule

// File: tb/tb_bigint_smul_seq.sv
module tb_bigint_smul_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_valid;
    logic [63:0] start_scalar;
    logic [7:0]  start_count;
    logic        start_err, busy;
    logic        in_valid;
    logic [63:0] in_limb;
    logic        in_ready;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_last;
    logic        out_ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [63:0] limbs [256];
    logic [63:0] expw  [257];

    always #10 clk = ~clk;

    bigint_smul_seq dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_scalar(start_scalar), .start_count(start_count),
        .start_err(start_err), .busy(busy),
        .in_valid(in_valid), .in_limb(in_limb), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // negate-magnitude formulation of unsigned*signed + sign-extended carry
    function automatic logic [127:0] ref_step(input logic [63:0] limb, input logic [63:0] sc,
                                              input logic [63:0] c);
        logic [127:0] mag, prod, cx;
        if (sc[63]) begin
            mag  = {64'd0, limb} * {64'd0, (~sc + 64'd1)};
            prod = ~mag + 128'd1;
        end else begin
            prod = {64'd0, limb} * {64'd0, sc};
        end
        cx = c[63] ? {64'hFFFF_FFFF_FFFF_FFFF, c} : {64'd0, c};
        return prod + cx;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    task automatic run_seq(input logic [63:0] sc, input int n, input int mode, input int stall);
        logic [63:0] c;
        logic [127:0] s;
        logic [63:0] held_d;
        logic held_l;
        bit hold_pend;
        int ii, oi, guard;
        bit ihs, ohs;
        for (int i = 0; i < n; i++) begin
            case (mode)
                1: limbs[i] = 64'hFFFF_FFFF_FFFF_FFFF;
                2: limbs[i] = 64'd0;
                default: limbs[i] = {$urandom, $urandom};
            endcase
        end
        c = 64'd0;
        for (int i = 0; i < n; i++) begin
            s = ref_step(limbs[i], sc, c);
            expw[i] = s[63:0];
            c = s[127:64];
        end
        expw[n] = c;

        @(negedge clk);
        start_valid  = 1'b1;
        start_scalar = sc;
        start_count  = 8'(n);
        @(negedge clk);
        start_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        chk(start_err == 1'b0, "R6 no err on nonzero count", 64'(start_err), 64'd0);

        ii = 0; oi = 0; guard = 0; hold_pend = 0;
        while (oi <= n && guard < 5000) begin
            guard++;
            in_valid  = (ii < n) && (($urandom % 4) != 0);
            in_limb   = (ii < n) ? limbs[ii] : 64'd0;
            out_ready = (stall == 0) || (($urandom % 3) != 0);
            if (busy && (($urandom % 8) == 0)) begin
                start_valid  = 1'b1;
                start_scalar = {$urandom, $urandom};
                start_count  = (($urandom % 2) == 0) ? 8'd0 : 8'd7;
            end else begin
                start_valid = 1'b0;
            end
            #1;
            chk(start_err == 1'b0, "R8 start while busy gives no err", 64'(start_err), 64'd0);
            if (hold_pend) begin
                chk(out_valid && out_data == held_d && out_last == held_l,
                    "R7 output held under stall", out_data, held_d);
                hold_pend = 0;
            end
            if (out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R7 input stalled", 64'(in_ready), 64'd0);
                held_d = out_data; held_l = out_last; hold_pend = 1;
            end
            ihs = in_valid && in_ready;
            ohs = out_valid && out_ready;
            if (ohs) begin
                if (oi < n) begin
                    chk(out_data == expw[oi], "R2 R3 R4 result limb", out_data, expw[oi]);
                    chk(out_last == 1'b0, "R4 limb not last", 64'(out_last), 64'd0);
                end else begin
                    chk(out_data == expw[oi], "R5 final carry word", out_data, expw[oi]);
                    chk(out_last == 1'b1, "R5 last flag", 64'(out_last), 64'd1);
                end
                oi++;
            end
            if (ihs) ii++;
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0; start_valid = 1'b0;
        chk(guard < 5000, "R4 sequence completes", 64'(oi), 64'(n + 1));
        chk(busy == 1'b0 && out_valid == 1'b0, "R5 R9 nothing after last word",
            {62'd0, busy, out_valid}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start_valid = 1'b0; start_scalar = '0; start_count = '0;
        in_valid = 1'b0; in_limb = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 0 && in_ready == 0 && busy == 0 && start_err == 0, "R1 reset state",
            {60'd0, out_valid, in_ready, busy, start_err}, 64'd0);

        // R6 zero count refused
        @(negedge clk);
        start_valid = 1'b1; start_scalar = 64'd5; start_count = 8'd0;
        @(negedge clk);
        start_valid = 1'b0;
        chk(start_err == 1'b1, "R6 err pulse", 64'(start_err), 64'd1);
        chk(busy == 1'b0 && out_valid == 1'b0, "R6 no sequence", {62'd0, busy, out_valid}, 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        chk(start_err == 1'b0, "R6 err one cycle", 64'(start_err), 64'd0);
        chk(out_valid == 1'b0, "R6 no output", 64'(out_valid), 64'd0);
        out_ready = 1'b0;

        // directed corners
        run_seq(64'd0, 3, 0, 0);
        run_seq(64'hFFFF_FFFF_FFFF_FFFF, 4, 1, 1);
        run_seq(64'h8000_0000_0000_0000, 5, 1, 1);
        run_seq(64'h7FFF_FFFF_FFFF_FFFF, 4, 1, 0);
        run_seq(64'h8000_0000_0000_0000, 2, 2, 1);
        run_seq(64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 1);
        run_seq({$urandom, $urandom}, 255, 0, 1);

        // random
        for (int k = 0; k < 25; k++) begin
            run_seq({$urandom, $urandom}, 1 + ($urandom % 40), 0, k % 2);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule